// File: doc/BRIEF.md
# Indirect Register and Memory Access Port

This block lets a host that only sees a small window of 16-bit I/O registers reach two larger internal spaces: a file of 16-bit control registers and a memory of 24-bit words. Each space has its own pointer register and its own data register. The host first writes a pointer that carries the target word address and the transfer attributes. It then moves the word through the matching data register. The block turns these host writes into write strobes to the internal storage that last one cycle. It also fetches read data into the data register, where the host picks it up.

For the memory space the pointer also selects the word width. A wide transfer moves a full 24-bit word as two host accesses, low half first. A narrow transfer moves only bits 15:0. The pointer never advances by itself, so every access needs a fresh pointer write. Both internal spaces are modelled inside the block as plain arrays.

Top module: `iap_top`

Host register offsets on `host_addr`: 0 control pointer, 1 control data, 2 memory pointer, 3 memory data low, 4 memory data high. Offsets 5 to 7 read as zero.

Control pointer layout: bits CREG_AW-1:0 hold the word address and bit 15 is the direction (1 = read). Memory pointer layout: bits MEM_AW-1:0 hold the word address, bit 14 is the width (1 = 24-bit) and bit 15 is the direction (1 = read).

## Requirements
- R1: After reset, every host register (offsets 0 to 4) reads as 0x0000.
- R2: With the control pointer set to write direction, a host write to offset 1 stores the 16-bit value in the addressed control register, and the data register then reads back that value.
- R3: A control pointer write with bit 15 set loads the addressed control register into the control data register one clock after the pointer write.
- R4: A host write whose byte-enable `host_be` is not 2'b11 changes no register and no stored word.
- R5: In wide write mode, writing offset 3 only latches bits 15:0. The 24-bit word {offset-4 bits 7:0, latched low half} is stored when offset 4 is written.
- R6: In narrow write mode, writing offset 3 stores the value immediately with bits 23:16 cleared, and a write to offset 4 is ignored.
- R7: A wide read pointer write loads the full 24-bit word: offset 3 returns bits 15:0 and offset 4 returns bits 23:16 in its bits 7:0, with its upper bits zero.
- R8: A narrow read pointer write loads only bits 15:0 of the word, so offset 4 then reads 0x0000.
- R9: Pointers never auto-increment. Repeated data writes hit the same word, and the pointer reads back unchanged after data accesses.
- R10: Data register writes made while the matching pointer is in read direction are ignored. Neither storage nor the data register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_be | input | 2 | Host byte enables, both must be set for a write to take effect |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Contents of the register selected by host_addr |

## Verification
The bench builds the block with its defaults: 16 control registers and a 64-word memory. At that size every pointer field is narrower than the reserved upper bits, so the bench can reach the readback of the direction and width bits as well as their independence from the address field. Wide and narrow transfers are run against the same memory words. This brings into reach the cases where a half-finished wide write must leave stored data untouched and where a narrow read must clear the high byte of a register that earlier held a wide value.

// File: rtl/iap_pkg.sv
package iap_pkg;
    localparam int HOST_AW = 3;
    localparam int HOST_DW = 16;

    localparam logic [HOST_AW-1:0] OFS_CPTR = 3'd0;
    localparam logic [HOST_AW-1:0] OFS_CDAT = 3'd1;
    localparam logic [HOST_AW-1:0] OFS_MPTR = 3'd2;
    localparam logic [HOST_AW-1:0] OFS_MDLO = 3'd3;
    localparam logic [HOST_AW-1:0] OFS_MDHI = 3'd4;

    localparam int DIR_BIT  = 15;
    localparam int WIDE_BIT = 14;
endpackage

// File: rtl/iap_store.sv
module iap_store #(
    parameter int W  = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[addr] <= wdata;
        end
    end

    assign rdata = words[addr];
endmodule

// File: rtl/iap_ctrl.sv
module iap_ctrl
    import iap_pkg::*;
#(
    parameter int CREG_AW = 4,
    parameter int MEM_AW  = 6,
    parameter int MEM_W   = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [1:0]         host_be,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic [CREG_AW-1:0] cr_addr,
    output logic               cr_we,
    output logic [HOST_DW-1:0] cr_wdata,
    input  logic [HOST_DW-1:0] cr_rdata,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic               mem_we,
    output logic [MEM_W-1:0]   mem_wdata,
    input  logic [MEM_W-1:0]   mem_rdata
);
    localparam int HI_W = MEM_W - HOST_DW;

    typedef struct packed {
        logic [CREG_AW-1:0] c_addr;
        logic               c_rd;
        logic               c_pend;
        logic [HOST_DW-1:0] c_data;
        logic [MEM_AW-1:0]  m_addr;
        logic               m_rd;
        logic               m_wide;
        logic               m_pend;
        logic [MEM_W-1:0]   m_data;
    } state_t;

    state_t s_d, s_q;
    logic   full_wr;

    always_comb begin
        s_d       = s_q;
        cr_we     = 1'b0;
        mem_we    = 1'b0;
        cr_wdata  = host_wdata;
        mem_wdata = {{HI_W{1'b0}}, host_wdata};
        full_wr   = host_wr && (host_be == 2'b11);

        if (s_q.c_pend) begin
            s_d.c_data = cr_rdata;
            s_d.c_pend = 1'b0;
        end
        if (s_q.m_pend) begin
            s_d.m_data = s_q.m_wide ? mem_rdata
                                    : {{HI_W{1'b0}}, mem_rdata[HOST_DW-1:0]};
            s_d.m_pend = 1'b0;
        end

        if (full_wr) begin
            unique case (host_addr)
                OFS_CPTR: begin
                    s_d.c_addr = host_wdata[CREG_AW-1:0];
                    s_d.c_rd   = host_wdata[DIR_BIT];
                    s_d.c_pend = host_wdata[DIR_BIT];
                end
                OFS_CDAT: begin
                    if (!s_q.c_rd) begin
                        s_d.c_data = host_wdata;
                        cr_we      = 1'b1;
                    end
                end
                OFS_MPTR: begin
                    s_d.m_addr = host_wdata[MEM_AW-1:0];
                    s_d.m_rd   = host_wdata[DIR_BIT];
                    s_d.m_wide = host_wdata[WIDE_BIT];
                    s_d.m_pend = host_wdata[DIR_BIT];
                end
                OFS_MDLO: begin
                    if (!s_q.m_rd) begin
                        s_d.m_data[HOST_DW-1:0] = host_wdata;
                        if (!s_q.m_wide) begin
                            s_d.m_data[MEM_W-1:HOST_DW] = '0;
                            mem_we = 1'b1;
                        end
                    end
                end
                OFS_MDHI: begin
                    if (!s_q.m_rd && s_q.m_wide) begin
                        s_d.m_data[MEM_W-1:HOST_DW] = host_wdata[HI_W-1:0];
                        mem_wdata = {host_wdata[HI_W-1:0], s_q.m_data[HOST_DW-1:0]};
                        mem_we    = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            OFS_CPTR: begin
                host_rdata[CREG_AW-1:0] = s_q.c_addr;
                host_rdata[DIR_BIT]     = s_q.c_rd;
            end
            OFS_CDAT: host_rdata = s_q.c_data;
            OFS_MPTR: begin
                host_rdata[MEM_AW-1:0] = s_q.m_addr;
                host_rdata[WIDE_BIT]   = s_q.m_wide;
                host_rdata[DIR_BIT]    = s_q.m_rd;
            end
            OFS_MDLO: host_rdata = s_q.m_data[HOST_DW-1:0];
            OFS_MDHI: host_rdata[HI_W-1:0] = s_q.m_data[MEM_W-1:HOST_DW];
            default:  host_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cr_addr  = s_q.c_addr;
    assign mem_addr = s_q.m_addr;
endmodule

// File: rtl/iap_top.sv
module iap_top
    import iap_pkg::*;
#(
    parameter int CREG_AW = 4,
    parameter int MEM_AW  = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_wr,
    input  logic [1:0]   host_be,
    input  logic [2:0]   host_addr,
    input  logic [15:0]  host_wdata,
    output logic [15:0]  host_rdata
);
    localparam int MEM_W = 24;

    logic [CREG_AW-1:0] cr_addr;
    logic               cr_we;
    logic [HOST_DW-1:0] cr_wdata;
    logic [HOST_DW-1:0] cr_rdata;
    logic [MEM_AW-1:0]  mem_addr;
    logic               mem_we;
    logic [MEM_W-1:0]   mem_wdata;
    logic [MEM_W-1:0]   mem_rdata;

    iap_ctrl #(
        .CREG_AW (CREG_AW),
        .MEM_AW  (MEM_AW),
        .MEM_W   (MEM_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_be    (host_be),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .cr_addr    (cr_addr),
        .cr_we      (cr_we),
        .cr_wdata   (cr_wdata),
        .cr_rdata   (cr_rdata),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    iap_store #(.W(HOST_DW), .AW(CREG_AW)) creg_i (
        .clk   (clk),
        .we    (cr_we),
        .addr  (cr_addr),
        .wdata (cr_wdata),
        .rdata (cr_rdata)
    );

    iap_store #(.W(MEM_W), .AW(MEM_AW)) mem_i (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );
endmodule

// File: rtl/iap_chk.sv
module iap_chk
    import iap_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic [1:0]  host_be,
    input logic [2:0]  host_addr,
    input logic        cr_we,
    input logic        mem_we,
    input logic [23:0] mem_wdata
);
    // R4: partial byte enables never reach storage
    p_partial_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_be != 2'b11) |-> (!cr_we && !mem_we));

    // R2: a control store only comes from a host write to the control data offset
    p_cwe_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> (host_wr && host_addr == OFS_CDAT));

    // R5: a memory store only comes from a host write to a memory data offset
    p_mwe_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (host_wr && (host_addr == OFS_MDLO || host_addr == OFS_MDHI)));

    // R6: a store triggered by the low half is narrow and clears the high byte
    p_narrow_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && host_addr == OFS_MDLO) |-> (mem_wdata[23:16] == 8'h00));

    // R2: one host access never strobes both spaces
    p_single_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cr_we, mem_we}));
endmodule

bind iap_top iap_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_be   (host_be),
    .host_addr (host_addr),
    .cr_we     (cr_we),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
);

// File: tb/iap_top_tb.sv
module iap_top_tb_top;
    localparam int CAW = 4;
    localparam int MAW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_be = 2'b11;
    logic [2:0]  host_addr = 3'd0;
    logic [15:0] host_wdata = 16'h0000;
    logic [15:0] host_rdata;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string phase = "R1";

    // behavioural reference state
    logic [15:0] c_mem [1 << CAW];
    logic [23:0] m_mem [1 << MAW];
    int          rc_addr, rm_addr;
    bit          rc_rd, rc_pend, rm_rd, rm_wide, rm_pend;
    logic [15:0] rc_data;
    logic [23:0] rm_data;

    iap_top #(.CREG_AW(CAW), .MEM_AW(MAW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_be    (host_be),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    always #2 clk = ~clk;

    function automatic logic [15:0] ref_read(input logic [2:0] a);
        case (a)
            3'd0: return {rc_rd, 15'(rc_addr)};
            3'd1: return rc_data;
            3'd2: return {rm_rd, rm_wide, 14'(rm_addr)};
            3'd3: return rm_data[15:0];
            3'd4: return {8'h00, rm_data[23:16]};
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            rc_addr = 0; rc_rd = 0; rc_pend = 0; rc_data = '0;
            rm_addr = 0; rm_rd = 0; rm_wide = 0; rm_pend = 0; rm_data = '0;
        end else begin
            if (rc_pend) begin rc_data = c_mem[rc_addr]; rc_pend = 0; end
            if (rm_pend) begin
                rm_data = rm_wide ? m_mem[rm_addr] : {8'h00, m_mem[rm_addr][15:0]};
                rm_pend = 0;
            end
            if (host_wr && host_be == 2'b11) begin
                case (host_addr)
                    3'd0: begin
                        rc_addr = int'(host_wdata[CAW-1:0]);
                        rc_rd = host_wdata[15]; rc_pend = host_wdata[15];
                    end
                    3'd1: if (!rc_rd) begin
                        rc_data = host_wdata; c_mem[rc_addr] = host_wdata;
                    end
                    3'd2: begin
                        rm_addr = int'(host_wdata[MAW-1:0]);
                        rm_rd = host_wdata[15]; rm_wide = host_wdata[14];
                        rm_pend = host_wdata[15];
                    end
                    3'd3: if (!rm_rd) begin
                        if (rm_wide) rm_data[15:0] = host_wdata;
                        else begin
                            rm_data = {8'h00, host_wdata};
                            m_mem[rm_addr] = rm_data;
                        end
                    end
                    3'd4: if (!rm_rd && rm_wide) begin
                        rm_data[23:16] = host_wdata[7:0];
                        m_mem[rm_addr] = rm_data;
                    end
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (host_rdata !== ref_read(host_addr)) begin
                n_errors++;
                $display("FAIL %s: cycle compare offset %0d actual %h expected %h",
                         phase, host_addr, host_rdata, ref_read(host_addr));
            end
        end
    end

    task automatic hw(input logic [2:0] a, input logic [15:0] d,
                      input logic [1:0] be = 2'b11);
        host_addr = a; host_wdata = d; host_be = be; host_wr = 1'b1;
        @(negedge clk); #1;
        host_wr = 1'b0; host_be = 2'b11;
    endtask

    task automatic chk(input logic [2:0] a, input logic [15:0] exp, input string req);
        host_addr = a;
        @(negedge clk);
        n_checks++;
        if (host_rdata !== exp) begin
            n_errors++;
            $display("FAIL %s: offset %0d actual %h expected %h", req, a, host_rdata, exp);
        end
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        phase = "R1";
        for (int i = 0; i < 5; i++) chk(3'(i), 16'h0000, "R1");

        phase = "R2";
        hw(3'd0, 16'h0005); hw(3'd1, 16'h1234);
        chk(3'd1, 16'h1234, "R2");
        hw(3'd0, 16'h0003); hw(3'd1, 16'hBEEF);

        phase = "R3";
        hw(3'd0, 16'h8003);
        chk(3'd1, 16'hBEEF, "R3");
        hw(3'd0, 16'h8005);
        chk(3'd1, 16'h1234, "R3");

        phase = "R4";
        hw(3'd0, 16'h0003);
        hw(3'd1, 16'h1111, 2'b01);
        hw(3'd0, 16'h0009, 2'b10);
        chk(3'd0, 16'h0003, "R4");
        hw(3'd0, 16'h8003);
        chk(3'd1, 16'hBEEF, "R4");

        phase = "R5";
        hw(3'd2, 16'h4008); hw(3'd3, 16'h1111); hw(3'd4, 16'h0022);
        hw(3'd2, 16'h4008); hw(3'd3, 16'h3333);
        hw(3'd2, 16'hC008);
        chk(3'd3, 16'h1111, "R5");
        chk(3'd4, 16'h0022, "R5");
        hw(3'd2, 16'h4007); hw(3'd3, 16'hABCD); hw(3'd4, 16'hFF12);

        phase = "R7";
        hw(3'd2, 16'hC007);
        chk(3'd3, 16'hABCD, "R7");
        chk(3'd4, 16'h0012, "R7");

        phase = "R6";
        hw(3'd2, 16'h0009); hw(3'd3, 16'h5A5A); hw(3'd4, 16'h00FF);
        hw(3'd2, 16'hC009);
        chk(3'd3, 16'h5A5A, "R6");
        chk(3'd4, 16'h0000, "R6");

        phase = "R8";
        hw(3'd2, 16'h8007);
        chk(3'd3, 16'hABCD, "R8");
        chk(3'd4, 16'h0000, "R8");

        phase = "R9";
        hw(3'd2, 16'h000A); hw(3'd3, 16'h1111); hw(3'd3, 16'h2222);
        chk(3'd2, 16'h000A, "R9");
        hw(3'd2, 16'hC00A);
        chk(3'd3, 16'h2222, "R9");
        chk(3'd4, 16'h0000, "R9");
        chk(3'd2, 16'hC00A, "R9");

        phase = "R10";
        hw(3'd0, 16'h8003); hw(3'd1, 16'h7777);
        chk(3'd1, 16'hBEEF, "R10");
        hw(3'd0, 16'h8003);
        chk(3'd1, 16'hBEEF, "R10");
        hw(3'd2, 16'hC007); hw(3'd3, 16'h9999); hw(3'd4, 16'h0044);
        chk(3'd3, 16'hABCD, "R10");
        chk(3'd4, 16'h0012, "R10");
        hw(3'd2, 16'hC007);
        chk(3'd3, 16'hABCD, "R10");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule